// File: doc/BRIEF.md
# Critical-Word-First Line Fill Controller

This controller services one cache miss at a time by fetching the whole line from memory, and it starts with the word that caused the miss. When the miss is accepted, it issues a single burst request that carries the line address and the missing word's offset. Memory then returns one word per beat in wrapped order: the missing offset first, then the higher offsets up to the end of the line, then offset zero up to the word just below the missing one. The first beat goes straight to the processor response port, so the processor can resume while the rest of the line is still arriving.

Every beat is written into the cache data array at its real offset, one word per write. The controller also keeps its own copy of the words that have already arrived. After the critical word has been returned, the processor may read other words of the same line. A word that is already present comes back on the next cycle. A word that is still missing is held as one pending read and is answered on the cycle after its beat arrives. When the last word has been written, a one-cycle done strobe tells the tag logic to mark the line valid. Until that strobe appears, new misses are held off.

Top module: `cwf_fill`

## Requirements
- R1: While reset is high and in the first cycle after it, `miss_ready` is 1 and `mem_req_valid`, `rd_ready`, `rsp_valid`, `wr_en` and `fill_done` are 0.
- R2: A miss is accepted on a rising edge where `miss_valid` and `miss_ready` are both 1. In the following cycle only, `mem_req_valid` is 1, with `mem_req_line` and `mem_req_off` equal to the accepted line and offset.
- R3: Beat i (counting from 0) of a fill holds the word at offset (k+i) mod WORDS, where k is the miss offset. One cycle after each beat, `wr_en` is 1 and `wr_off`, `wr_data` and `wr_line` give that offset, the beat data and the filling line.
- R4: One cycle after the first beat, `rsp_valid` is 1 and `rsp_data` equals that beat. Beats after the first produce no response unless they satisfy a pending read (R6).
- R5: `rd_ready` is 1 only while a fill is in progress, after its first beat, and when no read is pending. A read accepted then, to the filling line, whose word has already arrived (or arrives on the same edge), is answered with that word one cycle later.
- R6: A read accepted under R5 whose word has not yet arrived drops `rd_ready` to 0. The read is answered one cycle after the beat carrying that word, and `rd_ready` then returns to 1.
- R7: A read whose line differs from the filling line, or one offered while `rd_ready` is 0, produces no response.
- R8: `fill_done` is 1 for exactly the cycle after the last word's write cycle, with `done_line` equal to the filled line. `wr_en` is 0 in that cycle.
- R9: `miss_ready` is 0 from the cycle after a miss is accepted until the `fill_done` cycle, where it returns to 1. A miss held on `miss_valid` during a fill raises no request until then.
- R10: Beats that arrive while no fill is in progress cause no write and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request present |
| miss_line | input | LINE_W | Line address of the miss |
| miss_off | input | OFF_W | Word offset that missed |
| miss_ready | output | 1 | Controller idle, miss can be taken |
| mem_req_valid | output | 1 | One-cycle burst request to memory |
| mem_req_line | output | LINE_W | Line address of the burst |
| mem_req_off | output | OFF_W | Starting (wrap) offset of the burst |
| mem_beat_valid | input | 1 | Memory returns one word this cycle |
| mem_beat_data | input | DATA_W | Returned word |
| rd_valid | input | 1 | Processor read to the filling line |
| rd_line | input | LINE_W | Line address of the read |
| rd_off | input | OFF_W | Word offset of the read |
| rd_ready | output | 1 | A read can be accepted this cycle |
| rsp_valid | output | 1 | Processor data-valid strobe |
| rsp_data | output | DATA_W | Word returned to the processor |
| wr_en | output | 1 | Data array write strobe |
| wr_line | output | LINE_W | Line being written |
| wr_off | output | OFF_W | Word offset being written |
| wr_data | output | DATA_W | Word being written |
| fill_done | output | 1 | Line complete, set its valid bit |
| done_line | output | LINE_W | Line that completed |

## Verification
Every result is registered. The burst request, each array write and each response to a beat or to an arrived-word read appear one cycle after the rising edge that samples their cause, and `fill_done` comes one cycle after the last write. The bench changes inputs on the falling edge and reads results at the next falling edge, which is exactly one registered stage later. Expected writes and responses are queued when their stimulus is driven, and a falling-edge monitor pops and compares them. The directed tasks also check, at that same falling edge, that each due strobe is present and that each forbidden one is absent.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_FILL  = 2'd1,
    FS_DRAIN = 2'd2
  } fill_state_e;
endpackage

// File: rtl/cwf_wrap_seq.sv
// Beat counter producing the wrapped word offset for each arriving beat.
module cwf_wrap_seq #(
  parameter int WORDS = 8,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OFF_W-1:0] start_off,
  input  logic             beat,
  output logic [OFF_W-1:0] beat_off,
  output logic             last
);
  logic [OFF_W-1:0] base_q;
  logic [OFF_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (start) begin
      base_q <= start_off;
      cnt_q  <= '0;
    end else if (beat) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // power-of-two line: offset arithmetic wraps by itself
  assign beat_off = base_q + cnt_q;
  assign last     = (cnt_q == OFF_W'(WORDS - 1));
endmodule

// File: rtl/cwf_line_buf.sv
// Per-word copy of the filling line with arrival flags.
module cwf_line_buf #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_arrived
);
  logic [DATA_W-1:0] word_q [WORDS];
  logic              have_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        have_q[w] <= 1'b0;
      end else if (wr && (wr_off == OFF_W'(w))) begin
        have_q[w] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr && (wr_off == OFF_W'(w))) begin
        word_q[w] <= wr_data;
      end
    end
  end

  assign rd_data    = word_q[rd_off];
  assign rd_arrived = have_q[rd_off];
endmodule

// File: rtl/cwf_fill.sv
module cwf_fill
  import cwf_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int DATA_W = 32,
  parameter int WORDS  = 8,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [LINE_W-1:0] miss_line,
  input  logic [OFF_W-1:0]  miss_off,
  output logic              miss_ready,
  output logic              mem_req_valid,
  output logic [LINE_W-1:0] mem_req_line,
  output logic [OFF_W-1:0]  mem_req_off,
  input  logic              mem_beat_valid,
  input  logic [DATA_W-1:0] mem_beat_data,
  input  logic              rd_valid,
  input  logic [LINE_W-1:0] rd_line,
  input  logic [OFF_W-1:0]  rd_off,
  output logic              rd_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              wr_en,
  output logic [LINE_W-1:0] wr_line,
  output logic [OFF_W-1:0]  wr_off,
  output logic [DATA_W-1:0] wr_data,
  output logic              fill_done,
  output logic [LINE_W-1:0] done_line
);
  fill_state_e       state_q;
  logic [LINE_W-1:0] line_q;
  logic              crit_seen_q;
  logic              pend_q;
  logic [OFF_W-1:0]  pend_off_q;

  logic              miss_acc, beat_acc, rd_acc, rd_now, pend_hit, beat_is_rd;
  logic [OFF_W-1:0]  beat_off;
  logic              beat_last;
  logic [DATA_W-1:0] buf_data;
  logic              buf_arrived;

  assign miss_ready = (state_q == FS_IDLE);
  assign rd_ready   = (state_q == FS_FILL) && crit_seen_q && !pend_q;
  assign miss_acc   = miss_valid && miss_ready;
  assign beat_acc   = mem_beat_valid && (state_q == FS_FILL);

  cwf_wrap_seq #(.WORDS(WORDS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (miss_acc),
    .start_off (miss_off),
    .beat      (beat_acc),
    .beat_off  (beat_off),
    .last      (beat_last)
  );

  cwf_line_buf #(.WORDS(WORDS), .DATA_W(DATA_W)) u_buf (
    .clk        (clk),
    .rst        (rst),
    .clear      (miss_acc),
    .wr         (beat_acc),
    .wr_off     (beat_off),
    .wr_data    (mem_beat_data),
    .rd_off     (rd_off),
    .rd_data    (buf_data),
    .rd_arrived (buf_arrived)
  );

  assign beat_is_rd = beat_acc && (beat_off == rd_off);
  assign rd_acc     = rd_valid && rd_ready && (rd_line == line_q);
  assign rd_now     = rd_acc && (buf_arrived || beat_is_rd);
  assign pend_hit   = pend_q && beat_acc && (beat_off == pend_off_q);

  // control state
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= FS_IDLE;
      line_q      <= '0;
      crit_seen_q <= 1'b0;
      pend_q      <= 1'b0;
      pend_off_q  <= '0;
    end else begin
      case (state_q)
        FS_IDLE:  if (miss_acc) state_q <= FS_FILL;
        FS_FILL:  if (beat_acc && beat_last) state_q <= FS_DRAIN;
        default:  state_q <= FS_IDLE;
      endcase
      if (miss_acc) begin
        line_q      <= miss_line;
        crit_seen_q <= 1'b0;
        pend_q      <= 1'b0;
      end else begin
        if (beat_acc) crit_seen_q <= 1'b1;
        if (pend_hit) begin
          pend_q <= 1'b0;
        end else if (rd_acc && !rd_now) begin
          pend_q     <= 1'b1;
          pend_off_q <= rd_off;
        end
      end
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req_valid <= 1'b0;
      rsp_valid     <= 1'b0;
      wr_en         <= 1'b0;
      fill_done     <= 1'b0;
    end else begin
      mem_req_valid <= miss_acc;
      rsp_valid     <= (beat_acc && !crit_seen_q) || pend_hit || rd_now;
      wr_en         <= beat_acc;
      fill_done     <= (state_q == FS_DRAIN);
    end
  end

  always_ff @(posedge clk) begin
    if (miss_acc) begin
      mem_req_line <= miss_line;
      mem_req_off  <= miss_off;
    end
    if ((beat_acc && !crit_seen_q) || pend_hit) begin
      rsp_data <= mem_beat_data;
    end else if (rd_now) begin
      rsp_data <= beat_is_rd ? mem_beat_data : buf_data;
    end
    wr_line   <= line_q;
    wr_off    <= beat_off;
    wr_data   <= mem_beat_data;
    done_line <= line_q;
  end
endmodule

// File: rtl/cwf_fill_chk.sv
module cwf_fill_chk (
  input logic clk,
  input logic rst,
  input logic miss_ready,
  input logic mem_req_valid,
  input logic mem_beat_valid,
  input logic rd_ready,
  input logic wr_en,
  input logic fill_done
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid); // R2

  AST_REQ_HOLDS_OFF_MISS: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !miss_ready); // R9

  AST_DONE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
    fill_done |-> $past(wr_en)); // R8

  AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    fill_done |-> !wr_en); // R8

  AST_READ_ONLY_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    rd_ready |-> !miss_ready); // R5

  AST_IDLE_BEAT_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (miss_ready && mem_beat_valid) |=> !wr_en); // R10
endmodule

bind cwf_fill cwf_fill_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .miss_ready     (miss_ready),
  .mem_req_valid  (mem_req_valid),
  .mem_beat_valid (mem_beat_valid),
  .rd_ready       (rd_ready),
  .wr_en          (wr_en),
  .fill_done      (fill_done)
);

// File: tb/cwf_fill_bench.sv
`timescale 1ns/1ps
module cwf_fill_bench;
  localparam int LINE_W = 26;
  localparam int DATA_W = 32;
  localparam int WORDS  = 8;
  localparam int OFF_W  = $clog2(WORDS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic              miss_valid = 1'b0;
  logic [LINE_W-1:0] miss_line = '0;
  logic [OFF_W-1:0]  miss_off = '0;
  logic              miss_ready;
  logic              mem_req_valid;
  logic [LINE_W-1:0] mem_req_line;
  logic [OFF_W-1:0]  mem_req_off;
  logic              mem_beat_valid = 1'b0;
  logic [DATA_W-1:0] mem_beat_data = '0;
  logic              rd_valid = 1'b0;
  logic [LINE_W-1:0] rd_line = '0;
  logic [OFF_W-1:0]  rd_off = '0;
  logic              rd_ready, rsp_valid, wr_en, fill_done;
  logic [DATA_W-1:0] rsp_data, wr_data;
  logic [LINE_W-1:0] wr_line, done_line;
  logic [OFF_W-1:0]  wr_off;

  always #2.5 clk = ~clk;

  cwf_fill #(.LINE_W(LINE_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_cwf_fill (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_line(miss_line), .miss_off(miss_off), .miss_ready(miss_ready),
    .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line), .mem_req_off(mem_req_off),
    .mem_beat_valid(mem_beat_valid), .mem_beat_data(mem_beat_data),
    .rd_valid(rd_valid), .rd_line(rd_line), .rd_off(rd_off), .rd_ready(rd_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .wr_en(wr_en), .wr_line(wr_line), .wr_off(wr_off), .wr_data(wr_data),
    .fill_done(fill_done), .done_line(done_line)
  );

  int checks = 0;
  int fails  = 0;
  logic [LINE_W-1:0] cur_line = '0;

  logic [OFF_W-1:0]  exp_wr_off_q [$];
  logic [DATA_W-1:0] exp_wr_data_q [$];
  logic [DATA_W-1:0] exp_rsp_q [$];
  string             exp_rsp_tag_q [$];

  function automatic logic [DATA_W-1:0] word_of(input logic [LINE_W-1:0] l, input int o);
    return 32'hC000_0000 ^ DATA_W'({l, 4'h0}) ^ DATA_W'(o);
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_en) begin
        if (exp_wr_off_q.size() == 0) begin
          check("R10", "unexpected array write", 1, 0);
        end else begin
          logic [OFF_W-1:0]  eo;
          logic [DATA_W-1:0] ed;
          eo = exp_wr_off_q.pop_front();
          ed = exp_wr_data_q.pop_front();
          check("R3", "write offset", wr_off, eo);
          check("R3", "write data", wr_data, ed);
          check("R3", "write line", wr_line, cur_line);
        end
      end
      if (rsp_valid) begin
        if (exp_rsp_q.size() == 0) begin
          check("R7", "unexpected response", rsp_data, 0);
        end else begin
          logic [DATA_W-1:0] er;
          string             et;
          er = exp_rsp_q.pop_front();
          et = exp_rsp_tag_q.pop_front();
          check(et, "response data", rsp_data, er);
        end
      end
    end
  end

  // all tasks are entered at a falling edge and leave at one
  task automatic miss(input logic [LINE_W-1:0] l, input int off);
    miss_valid = 1'b1; miss_line = l; miss_off = OFF_W'(off);
    @(negedge clk);
    miss_valid = 1'b0;
    cur_line = l;
    check("R2", "request strobe", mem_req_valid, 1);
    check("R2", "request line", mem_req_line, l);
    check("R2", "request offset", mem_req_off, off);
    check("R9", "miss_ready low during fill", miss_ready, 0);
  endtask

  task automatic beat(input int off, input bit crit, input bit exp_rsp, input string tag);
    mem_beat_valid = 1'b1;
    mem_beat_data  = word_of(cur_line, off);
    exp_wr_off_q.push_back(OFF_W'(off));
    exp_wr_data_q.push_back(word_of(cur_line, off));
    if (crit) begin
      exp_rsp_q.push_back(word_of(cur_line, off));
      exp_rsp_tag_q.push_back("R4");
    end
    @(negedge clk);
    mem_beat_valid = 1'b0;
    check("R3", "write one cycle after beat", wr_en, 1);
    check(tag, "response strobe after beat", rsp_valid, exp_rsp);
  endtask

  task automatic rd(input logic [LINE_W-1:0] l, input int off, input int mode, input string tag);
    // mode 0: answered next cycle, 1: pending, 2: dropped
    rd_valid = 1'b1; rd_line = l; rd_off = OFF_W'(off);
    if (mode != 2) begin
      exp_rsp_q.push_back(word_of(l, off));
      exp_rsp_tag_q.push_back(tag);
    end
    @(negedge clk);
    rd_valid = 1'b0;
    check(tag, "read response strobe", rsp_valid, mode == 0);
    if (mode == 1) check(tag, "rd_ready low while pending", rd_ready, 0);
  endtask

  task automatic finish_fill(input logic [LINE_W-1:0] l);
    check("R8", "no done in write cycle", fill_done, 0);
    @(negedge clk);
    check("R8", "fill_done strobe", fill_done, 1);
    check("R8", "done line", done_line, l);
    check("R8", "no write in done cycle", wr_en, 0);
    check("R9", "miss_ready back at done", miss_ready, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check("R1", "watchdog expired", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "miss_ready in reset", miss_ready, 1);
    check("R1", "request in reset", mem_req_valid, 0);
    check("R1", "rsp in reset", rsp_valid, 0);
    check("R1", "write in reset", wr_en, 0);
    check("R1", "done in reset", fill_done, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "miss_ready after reset", miss_ready, 1);
    check("R1", "rd_ready after reset", rd_ready, 0);

    // straight fill, miss in the middle of the line: order 3..7,0..2
    miss(26'h5, 3);
    check("R5", "rd_ready before critical word", rd_ready, 0);
    for (int i = 0; i < WORDS; i++) beat((3 + i) % WORDS, i == 0, i == 0, "R4");
    finish_fill(26'h5);

    // reads under fill, miss at offset 0, beats with gaps
    miss(26'h1234, 0);
    beat(0, 1'b1, 1'b1, "R4");
    check("R5", "rd_ready after critical word", rd_ready, 1);
    rd(26'h1234, 0, 0, "R5");
    beat(1, 1'b0, 1'b0, "R4");
    beat(2, 1'b0, 1'b0, "R4");
    rd(26'h1234, 1, 0, "R5");
    rd(26'h1235, 2, 2, "R7");
    check("R7", "rd_ready kept after dropped read", rd_ready, 1);
    rd(26'h1234, 6, 1, "R6");
    rd(26'h1234, 2, 2, "R7");
    beat(3, 1'b0, 1'b0, "R6");
    beat(4, 1'b0, 1'b0, "R6");
    beat(5, 1'b0, 1'b0, "R6");
    beat(6, 1'b0, 1'b1, "R6");
    check("R6", "rd_ready back after pending served", rd_ready, 1);
    beat(7, 1'b0, 1'b0, "R4");
    finish_fill(26'h1234);

    // wrap at the last word, second miss held during the fill
    miss(26'h9, 7);
    miss_valid = 1'b1; miss_line = 26'h77; miss_off = OFF_W'(2);
    for (int i = 0; i < WORDS; i++) begin
      beat((7 + i) % WORDS, i == 0, i == 0, "R4");
      check("R9", "held miss not requested", mem_req_valid, 0);
    end
    finish_fill(26'h9);
    @(negedge clk);
    miss_valid = 1'b0;
    cur_line = 26'h77;
    check("R9", "held miss requested after done", mem_req_valid, 1);
    check("R9", "held miss line", mem_req_line, 26'h77);
    check("R2", "held miss offset", mem_req_off, 2);
    for (int i = 0; i < WORDS; i++) beat((2 + i) % WORDS, i == 0, i == 0, "R4");
    finish_fill(26'h77);

    // beats with no fill in progress
    mem_beat_valid = 1'b1; mem_beat_data = 32'hDEAD_BEEF;
    @(negedge clk);
    @(negedge clk);
    mem_beat_valid = 1'b0;
    check("R10", "no write for idle beat", wr_en, 0);
    check("R10", "no response for idle beat", rsp_valid, 0);
    @(negedge clk);
    check("R10", "still idle", miss_ready, 1);

    check("R3", "write queue drained", exp_wr_off_q.size(), 0);
    check("R6", "response queue drained", exp_rsp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule